// File: doc/BRIEF.md
# Conditional Branch Resolver

This unit decides whether a conditional branch is taken and produces the address that fetch should use next. Each cycle it takes four status flags (carry, zero, sign, overflow), a 4-bit condition code, the address of the instruction that follows the branch, and a short signed displacement. One clock later it presents a taken bit and the next-fetch address.

The upper three bits of the condition code pick one of eight base tests. The lowest bit inverts the base test. The base tests cover single-flag checks, unsigned ordering, signed ordering, and an unconditional pair. Signed ordering is derived from sign XOR overflow. Unsigned ordering is derived from carry and zero. A taken branch targets the fall-through address plus the sign-extended displacement, wrapping modulo 2^ADDR_W. A branch that is not taken continues at the fall-through address.

Top module: `bce_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, br_taken is 0 and fetch_addr is 0.
- R2: Outputs are registered. A value driven on the inputs before a rising edge appears on the outputs after that edge, and not before.
- R3: Code 4'b0000 is taken exactly when flag_of is 1.
- R4: Code 4'b0010 is taken exactly when flag_cf is 1. Code 4'b0110 is taken exactly when flag_cf OR flag_zf is 1.
- R5: Code 4'b0100 is taken exactly when flag_zf is 1.
- R6: Code 4'b1000 is taken exactly when flag_sf is 1.
- R7: Code 4'b1100 is taken exactly when flag_sf XOR flag_of is 1. Code 4'b1110 is taken exactly when (flag_sf XOR flag_of) OR flag_zf is 1.
- R8: Any code with bit 0 set is taken exactly when the code with bit 0 cleared is not taken, for the same flags.
- R9: Code 4'b1010 is always taken, whatever the flags. Code 4'b1011 is never taken.
- R10: When taken, fetch_addr equals next_pc plus rel_disp sign-extended from DISP_W bits, modulo 2^ADDR_W. With the defaults this covers displacements from -128 to +127.
- R11: When not taken, fetch_addr equals next_pc, whatever rel_disp is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_cf | input | 1 | Carry flag |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_of | input | 1 | Overflow flag |
| cond_code | input | 4 | Bits 3:1 select the base test; bit 0 inverts it |
| next_pc | input | ADDR_W | Address of the instruction after the branch |
| rel_disp | input | DISP_W | Signed branch displacement |
| br_taken | output | 1 | Branch taken, registered |
| fetch_addr | output | ADDR_W | Next fetch address, registered |

## Verification
The bench builds the unit with ADDR_W=32 and DISP_W=8. This makes the 32-bit wrap of the target adder reachable in both directions, forward past the top of the address space and backward below zero. It also makes the displacement extremes +127 and -128 easy to drive. With only four flags and sixteen codes, every code is checked against every flag combination.

// File: rtl/bce_pkg.sv
package bce_pkg;

    localparam int COND_W = 4;

    typedef struct packed {
        logic cf;
        logic zf;
        logic sf;
        logic of;
    } bce_flags_t;

    typedef enum logic [2:0] {
        BASE_OVF      = 3'd0,
        BASE_BELOW    = 3'd1,
        BASE_EQ       = 3'd2,
        BASE_BELOW_EQ = 3'd3,
        BASE_NEG      = 3'd4,
        BASE_ALWAYS   = 3'd5,
        BASE_LESS     = 3'd6,
        BASE_LESS_EQ  = 3'd7
    } bce_base_e;

endpackage

// File: rtl/bce_cond_eval.sv
module bce_cond_eval
    import bce_pkg::*;
(
    input  bce_flags_t          flags,
    input  logic [COND_W-1:0]   cond,
    output logic                taken
);

    logic base_hit;
    logic signed_lt;

    always_comb begin
        signed_lt = flags.sf ^ flags.of;
        unique case (bce_base_e'(cond[COND_W-1:1]))
            BASE_OVF:      base_hit = flags.of;
            BASE_BELOW:    base_hit = flags.cf;
            BASE_EQ:       base_hit = flags.zf;
            BASE_BELOW_EQ: base_hit = flags.cf | flags.zf;
            BASE_NEG:      base_hit = flags.sf;
            BASE_ALWAYS:   base_hit = 1'b1;
            BASE_LESS:     base_hit = signed_lt;
            BASE_LESS_EQ:  base_hit = signed_lt | flags.zf;
            default:       base_hit = 1'b0;
        endcase
        taken = base_hit ^ cond[0];
    end

endmodule

// File: rtl/bce_target_adder.sv
module bce_target_adder #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 8
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] target
);

    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;

    generate
        if (EXT_W > 0) begin : g_extend
            assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        end else begin : g_trunc
            assign disp_ext = disp[ADDR_W-1:0];
        end
    endgenerate

    assign target = base_addr + disp_ext;

endmodule

// File: rtl/bce_unit.sv
module bce_unit
    import bce_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_cf,
    input  logic              flag_zf,
    input  logic              flag_sf,
    input  logic              flag_of,
    input  logic [COND_W-1:0] cond_code,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic [DISP_W-1:0] rel_disp,
    output logic              br_taken,
    output logic [ADDR_W-1:0] fetch_addr
);

    localparam int EXT_W = ADDR_W - DISP_W;

    typedef struct packed {
        logic              taken;
        logic [ADDR_W-1:0] addr;
        logic              past_ok;
    } state_t;

    state_t     state_d, state_q;
    bce_flags_t flags;
    logic       cond_hit;
    logic [ADDR_W-1:0] jump_addr;

    assign flags = '{cf: flag_cf, zf: flag_zf, sf: flag_sf, of: flag_of};

    bce_cond_eval u_cond (
        .flags (flags),
        .cond  (cond_code),
        .taken (cond_hit)
    );

    bce_target_adder #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W)
    ) u_adder (
        .base_addr (next_pc),
        .disp      (rel_disp),
        .target    (jump_addr)
    );

    always_comb begin
        state_d         = state_q;
        state_d.taken   = cond_hit;
        state_d.addr    = cond_hit ? jump_addr : next_pc;
        state_d.past_ok = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign br_taken   = state_q.taken;
    assign fetch_addr = state_q.addr;

    always @(posedge clk) begin
        if (rst_n && !state_q.past_ok) begin
            AST_RESET_CLEAR: assert (!br_taken && fetch_addr == '0); // R1
        end
    end

    AST_FALLTHRU_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.past_ok && !br_taken) |-> (fetch_addr == $past(next_pc))); // R11

    AST_TARGET_DELTA: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.past_ok && br_taken) |->
        ((fetch_addr - $past(next_pc)) ==
         ADDR_W'($signed({{EXT_W{$past(rel_disp[DISP_W-1])}}, $past(rel_disp)})))); // R10

    AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.past_ok && $past(cond_code) == 4'b1010) |-> br_taken); // R9

    AST_NEVER_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.past_ok && $past(cond_code) == 4'b1011) |-> !br_taken); // R9

    AST_EQ_FOLLOWS_ZF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.past_ok && $past(cond_code) == 4'b0100) |-> (br_taken == $past(flag_zf))); // R5

    AST_OVF_FOLLOWS_OF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.past_ok && $past(cond_code) == 4'b0000) |-> (br_taken == $past(flag_of))); // R3

endmodule

// File: tb/bce_unit_bench.sv
module bce_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int DISP_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cf = 0, zf = 0, sf = 0, of = 0;
    logic [3:0]        cond = 4'd0;
    logic [ADDR_W-1:0] pc = '0;
    logic [DISP_W-1:0] disp = '0;
    logic              taken;
    logic [ADDR_W-1:0] faddr;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bce_unit #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_bce_unit (
        .clk(clk), .rst_n(rst_n),
        .flag_cf(cf), .flag_zf(zf), .flag_sf(sf), .flag_of(of),
        .cond_code(cond), .next_pc(pc), .rel_disp(disp),
        .br_taken(taken), .fetch_addr(faddr)
    );

    function automatic logic model_taken(logic [3:0] c, logic fc, logic fz, logic fs, logic fo);
        logic b;
        case (c[3:1])
            3'd0: b = fo;
            3'd1: b = fc;
            3'd2: b = fz;
            3'd3: b = fc | fz;
            3'd4: b = fs;
            3'd5: b = 1'b1;
            3'd6: b = fs ^ fo;
            default: b = (fs ^ fo) | fz;
        endcase
        return b ^ c[0];
    endfunction

    task automatic check(string req, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(logic [3:0] c, logic [3:0] f, logic [ADDR_W-1:0] p, logic [DISP_W-1:0] d);
        @(negedge clk);
        cond = c; {cf, zf, sf, of} = f; pc = p; disp = d;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        cond = 4'b1010; pc = 32'h1234_5678; disp = 8'h10;
        repeat (3) @(negedge clk);
        check("R1 taken in reset", {31'b0, taken}, 32'd0);
        check("R1 addr in reset", faddr, 32'd0);
        rst_n = 1'b1;
        check("R1 taken after release", {31'b0, taken}, 32'd0);
        check("R1 addr after release", faddr, 32'd0);
    endtask

    task automatic t_single(string req, logic [3:0] c, int fbit);
        for (int v = 0; v < 2; v++) begin
            logic [3:0] f = 4'b0000;
            f[fbit] = v[0];
            drive(c, f, 32'h0000_1000, 8'h04);
            check(req, {31'b0, taken}, {31'b0, v[0]});
        end
    endtask

    task automatic t_compound;
        for (int f = 0; f < 16; f++) begin
            logic [3:0] fl = f[3:0];
            drive(4'b0110, fl, 32'h100, 8'h02);
            check("R4 below-or-equal", {31'b0, taken}, {31'b0, fl[3] | fl[2]});
            drive(4'b1100, fl, 32'h100, 8'h02);
            check("R7 signed less", {31'b0, taken}, {31'b0, fl[1] ^ fl[0]});
            drive(4'b1110, fl, 32'h100, 8'h02);
            check("R7 signed less-or-equal", {31'b0, taken}, {31'b0, (fl[1] ^ fl[0]) | fl[2]});
        end
    endtask

    task automatic t_negate_all;
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                logic [3:0] fl = f[3:0];
                logic e = model_taken(c[3:0], fl[3], fl[2], fl[1], fl[0]);
                drive(c[3:0], fl, 32'h2000, 8'hF0);
                check("R8 code/flag sweep", {31'b0, taken}, {31'b0, e});
            end
        end
    endtask

    task automatic t_always;
        for (int f = 0; f < 16; f++) begin
            drive(4'b1010, f[3:0], 32'h40, 8'h01);
            check("R9 always", {31'b0, taken}, 32'd1);
            drive(4'b1011, f[3:0], 32'h40, 8'h01);
            check("R9 never", {31'b0, taken}, 32'd0);
        end
    endtask

    task automatic t_targets;
        drive(4'b1010, 4'b0, 32'hFFFF_FFF0, 8'h7F);
        check("R10 forward wrap", faddr, 32'h0000_006F);
        drive(4'b1010, 4'b0, 32'h0000_0005, 8'h80);
        check("R10 backward wrap", faddr, 32'hFFFF_FF85);
        drive(4'b1010, 4'b0, 32'h0000_1000, 8'hFF);
        check("R10 minus one", faddr, 32'h0000_0FFF);
        drive(4'b1010, 4'b0, 32'h0000_1000, 8'h00);
        check("R10 zero disp", faddr, 32'h0000_1000);
        drive(4'b1011, 4'b0, 32'hABCD_0000, 8'h7F);
        check("R11 not taken addr", faddr, 32'hABCD_0000);
        drive(4'b0100, 4'b0000, 32'h0000_0010, 8'h80);
        check("R11 equal miss", faddr, 32'h0000_0010);
    endtask

    task automatic t_registered;
        drive(4'b1011, 4'b0, 32'h0000_0100, 8'h08);
        @(negedge clk);
        cond = 4'b1010; pc = 32'h0000_0200;
        #1;
        check("R2 holds before edge", faddr, 32'h0000_0100);
        check("R2 taken holds", {31'b0, taken}, 32'd0);
        @(negedge clk);
        check("R2 updates after edge", faddr, 32'h0000_0208);
    endtask

    initial begin
        t_reset();
        t_single("R3 overflow", 4'b0000, 0);
        t_single("R4 below", 4'b0010, 3);
        t_single("R5 equal", 4'b0100, 2);
        t_single("R6 sign", 4'b1000, 1);
        t_compound();
        t_negate_all();
        t_always();
        t_targets();
        t_registered();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule